// File: doc/BRIEF.md
# BCH Correction Applier

This block sits behind a BCH decoder on a flash read path and turns the decoder's result for one 512-byte sector into bit-flip commands. After the caller names a sector and pulses `start`, the block waits for that sector's completion flag. It then takes the sector's error count from a packed count word and walks the error locations, which come two to a 32-bit word. It issues one flip command per clock. Each command carries a byte address and a one-hot bit mask, and goes either to the sector data buffer or to the 8-byte metadata buffer.

Locations that point into the parity bytes, which follow the metadata, produce no flip. When the walk ends, the block gives a one-cycle result pulse. The pulse carries the number of bits actually corrected, or an uncorrectable flag. Computing syndromes and the error locator is outside this block.

Top module: `bch_fix_applier`

## Requirements
- R1: After reset, `dataFlip`, `metaFlip`, `resultValid` and `uncorrectable` are all low until a `start` pulse is accepted.
- R2: No flip command and no result pulse appear for sector n before bit n of `doneFlags` has been seen high.
- R3: The error count of sector n is taken from bits 4n+3 down to 4n of `errCounts`. The other fields have no effect.
- R4: A count of 4'hF produces no flip command and a result pulse with `uncorrectable` high and `fixedCount` zero.
- R5: A count of 13 or 14, which is above the 12-error maximum, is treated the same way as 4'hF.
- R6: Error 2k is read from bits 12:0 of word k of `locWords`, and error 2k+1 from bits 28:16 of the same word. Only errors below the count are used.
- R7: A location L below 4096 issues `dataFlip` with `flipByte` = L>>3 and `flipMask` = 1<<L[2:0].
- R8: A location L from 4096 to 4159 issues `metaFlip` with `flipByte` = (L>>3)−512 and `flipMask` = 1<<L[2:0].
- R9: A location of 4160 or above issues no flip and is not counted.
- R10: Flip commands come at most one per clock, in increasing error index order.
- R11: `resultValid` is high for exactly one cycle per accepted `start`. `fixedCount` then equals the number of flips issued, which is zero for a count of zero.
- R12: A `start` pulse that arrives while a sector is being handled is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin handling the sector on `sectorIdx` |
| sectorIdx | input | 3 | Sector to handle, sampled with `start` |
| doneFlags | input | 8 | Per-sector decoder completion flags, bit n for sector n |
| errCounts | input | 32 | Packed 4-bit error counts, one per sector |
| locWords | input | 192 | Six location words, two 13-bit locations each |
| dataFlip | output | 1 | Flip command for the data buffer |
| metaFlip | output | 1 | Flip command for the metadata buffer |
| flipByte | output | 9 | Byte address of the current flip |
| flipMask | output | 8 | One-hot bit mask of the current flip |
| resultValid | output | 1 | One-cycle result pulse |
| uncorrectable | output | 1 | Sector could not be corrected (valid with `resultValid`) |
| fixedCount | output | 4 | Number of bits corrected (valid with `resultValid`) |

## Verification
A vector table drives sectors with locations in each region and on each boundary: 4095/4096, 4159/4160, bit 0 and bit 7, and the last parity location 8191. Because each case leaves different routing, counts and addresses, the runs tell the three regions apart. Other count fields are set to nonzero junk, and the location words are padded with junk beyond the count. This separates correct field and word selection from off-by-one selection. Directed runs cover the following cases:
- a count of 4'hF and a count of 13;
- a full set of twelve errors that reaches the odd half of the last word;
- a completion flag that arrives several cycles late;
- a second `start` issued while the block is busy.

// File: rtl/bch_fix_pkg.sv
package bch_fix_pkg;
  typedef struct packed {
    logic latchSec;
    logic capture;
    logic step;
    logic report;
  } fixStrobes_t;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_WAIT   = 2'd1,
    ST_ISSUE  = 2'd2,
    ST_REPORT = 2'd3
  } fixState_t;
endpackage

// File: rtl/bch_fix_ctrl.sv
module bch_fix_ctrl
  import bch_fix_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        doneHit,
  input  logic        liveBad,
  input  logic        liveZero,
  input  logic        lastIdx,
  output fixStrobes_t strobes
);
  fixState_t state, nextState;

  always_comb begin
    nextState = state;
    strobes   = '0;
    unique case (state)
      ST_IDLE: if (start) begin
        strobes.latchSec = 1'b1;
        nextState = ST_WAIT;
      end
      ST_WAIT: if (doneHit) begin
        strobes.capture = 1'b1;
        nextState = (liveBad || liveZero) ? ST_REPORT : ST_ISSUE;
      end
      ST_ISSUE: begin
        strobes.step = 1'b1;
        if (lastIdx) nextState = ST_REPORT;
      end
      ST_REPORT: begin
        strobes.report = 1'b1;
        nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  // R2
  wait_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ISSUE && $past(state) == ST_WAIT) |-> $past(doneHit));

  // R12
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE) |-> !strobes.latchSec);
endmodule

// File: rtl/bch_fix_dp.sv
module bch_fix_dp
  import bch_fix_pkg::*;
#(
  parameter int SECTOR_BYTES = 512,
  parameter int META_BYTES   = 8,
  parameter int MAX_ERRS     = 12,
  parameter int NUM_SECTORS  = 8,
  parameter int LOC_W        = 13,
  localparam int NUM_WORDS   = (MAX_ERRS + 1) / 2,
  localparam int SEC_W       = $clog2(NUM_SECTORS),
  localparam int BYTE_W      = $clog2(SECTOR_BYTES),
  localparam int CNT_W       = 4
)(
  input  logic                     clk,
  input  logic                     rstN,
  input  fixStrobes_t              strobes,
  input  logic [SEC_W-1:0]         sectorIdx,
  input  logic [NUM_SECTORS-1:0]   doneFlags,
  input  logic [NUM_SECTORS*CNT_W-1:0] errCounts,
  input  logic [NUM_WORDS*32-1:0]  locWords,
  output logic                     doneHit,
  output logic                     liveBad,
  output logic                     liveZero,
  output logic                     lastIdx,
  output logic                     dataFlip,
  output logic                     metaFlip,
  output logic [BYTE_W-1:0]        flipByte,
  output logic [7:0]               flipMask,
  output logic                     resultValid,
  output logic                     uncorrectable,
  output logic [CNT_W-1:0]         fixedCount
);
  localparam logic [LOC_W-1:0] DATA_END = LOC_W'(SECTOR_BYTES * 8);
  localparam logic [LOC_W-1:0] META_END = LOC_W'((SECTOR_BYTES + META_BYTES) * 8);
  localparam logic [LOC_W-4:0] META_BASE = (LOC_W-3)'(SECTOR_BYTES);
  localparam logic [CNT_W-1:0] BAD_CODE = '1;
  localparam logic [CNT_W-1:0] MAX_CNT  = CNT_W'(MAX_ERRS);

  logic [SEC_W-1:0]        secReg;
  logic [NUM_WORDS*32-1:0] locReg;
  logic [CNT_W-1:0]        cntReg, idx, fixCnt, liveCnt;
  logic                    badReg;
  logic [31:0]             curWord;
  logic [LOC_W-1:0]        curLoc;
  logic [LOC_W-4:0]        byteFull, metaByte;
  logic                    inData, inMeta;

  assign liveCnt  = errCounts[secReg*CNT_W +: CNT_W];
  assign doneHit  = doneFlags[secReg];
  assign liveBad  = (liveCnt == BAD_CODE) || (liveCnt > MAX_CNT);
  assign liveZero = (liveCnt == '0);
  assign lastIdx  = (idx == cntReg - 1'b1);

  assign curWord  = locReg[idx[CNT_W-1:1]*32 +: 32];
  assign curLoc   = idx[0] ? curWord[16 +: LOC_W] : curWord[0 +: LOC_W];
  assign byteFull = curLoc[LOC_W-1:3];
  assign metaByte = byteFull - META_BASE;
  assign inData   = (curLoc < DATA_END);
  assign inMeta   = !inData && (curLoc < META_END);

  assign dataFlip      = strobes.step && inData;
  assign metaFlip      = strobes.step && inMeta;
  assign flipByte      = inMeta ? metaByte[BYTE_W-1:0] : byteFull[BYTE_W-1:0];
  assign flipMask      = 8'b1 << curLoc[2:0];
  assign resultValid   = strobes.report;
  assign uncorrectable = strobes.report && badReg;
  assign fixedCount    = fixCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      secReg <= '0;
      locReg <= '0;
      cntReg <= '0;
      idx    <= '0;
      fixCnt <= '0;
      badReg <= 1'b0;
    end else begin
      if (strobes.latchSec) secReg <= sectorIdx;
      if (strobes.capture) begin
        locReg <= locWords;
        cntReg <= liveCnt;
        badReg <= liveBad;
        idx    <= '0;
        fixCnt <= '0;
      end else if (strobes.step) begin
        idx <= idx + 1'b1;
        if (inData || inMeta) fixCnt <= fixCnt + 1'b1;
      end
    end
  end

  // R11
  pulse_once_chk: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |=> !resultValid);

  // R9
  parity_skip_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.step && !dataFlip && !metaFlip) |=> (fixCnt == $past(fixCnt)));

  // R4
  bad_noflip_chk: assert property (@(posedge clk) disable iff (!rstN)
    badReg |-> !(dataFlip || metaFlip));

  // R10
  one_flip_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({dataFlip, metaFlip}));
endmodule

// File: rtl/bch_fix_applier.sv
module bch_fix_applier
  import bch_fix_pkg::*;
#(
  parameter int SECTOR_BYTES = 512,
  parameter int META_BYTES   = 8,
  parameter int MAX_ERRS     = 12,
  parameter int NUM_SECTORS  = 8,
  parameter int LOC_W        = 13,
  localparam int NUM_WORDS   = (MAX_ERRS + 1) / 2,
  localparam int SEC_W       = $clog2(NUM_SECTORS),
  localparam int BYTE_W      = $clog2(SECTOR_BYTES)
)(
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       start,
  input  logic [SEC_W-1:0]           sectorIdx,
  input  logic [NUM_SECTORS-1:0]     doneFlags,
  input  logic [NUM_SECTORS*4-1:0]   errCounts,
  input  logic [NUM_WORDS*32-1:0]    locWords,
  output logic                       dataFlip,
  output logic                       metaFlip,
  output logic [BYTE_W-1:0]          flipByte,
  output logic [7:0]                 flipMask,
  output logic                       resultValid,
  output logic                       uncorrectable,
  output logic [3:0]                 fixedCount
);
  fixStrobes_t strobes;
  logic doneHit, liveBad, liveZero, lastIdx;

  bch_fix_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .doneHit(doneHit),
    .liveBad(liveBad), .liveZero(liveZero), .lastIdx(lastIdx),
    .strobes(strobes)
  );

  bch_fix_dp #(
    .SECTOR_BYTES(SECTOR_BYTES), .META_BYTES(META_BYTES),
    .MAX_ERRS(MAX_ERRS), .NUM_SECTORS(NUM_SECTORS), .LOC_W(LOC_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .sectorIdx(sectorIdx),
    .doneFlags(doneFlags), .errCounts(errCounts), .locWords(locWords),
    .doneHit(doneHit), .liveBad(liveBad), .liveZero(liveZero),
    .lastIdx(lastIdx), .dataFlip(dataFlip), .metaFlip(metaFlip),
    .flipByte(flipByte), .flipMask(flipMask), .resultValid(resultValid),
    .uncorrectable(uncorrectable), .fixedCount(fixedCount)
  );
endmodule

// File: tb/bch_fix_applier_bench.sv
module bch_fix_applier_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [2:0] sectorIdx = '0;
  logic [7:0] doneFlags = '0;
  logic [31:0] errCounts = '0;
  logic [191:0] locWords = '0;
  logic dataFlip, metaFlip, resultValid, uncorrectable;
  logic [8:0] flipByte;
  logic [7:0] flipMask;
  logic [3:0] fixedCount;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  bch_fix_applier u_bch_fix_applier (
    .clk(clk), .rstN(rstN), .start(start), .sectorIdx(sectorIdx),
    .doneFlags(doneFlags), .errCounts(errCounts), .locWords(locWords),
    .dataFlip(dataFlip), .metaFlip(metaFlip), .flipByte(flipByte),
    .flipMask(flipMask), .resultValid(resultValid),
    .uncorrectable(uncorrectable), .fixedCount(fixedCount)
  );

  // {sector[2:0], count[3:0], doneDelay[3:0], loc0..loc3 [12:0] each}
  localparam int NV = 6;
  localparam logic [62:0] VEC [NV] = '{
    {3'd0, 4'd2, 4'd0, 13'h0005, 13'h0FFF, 13'h0AAA, 13'h0AAA},
    {3'd3, 4'd3, 4'd2, 13'h1000, 13'h103F, 13'h1040, 13'h0AAA},
    {3'd7, 4'd4, 4'd5, 13'h1FFF, 13'h0808, 13'h1009, 13'h0000},
    {3'd5, 4'd1, 4'd1, 13'h0123, 13'h0AAA, 13'h0AAA, 13'h0AAA},
    {3'd1, 4'd0, 4'd0, 13'h0AAA, 13'h0AAA, 13'h0AAA, 13'h0AAA},
    {3'd2, 4'd4, 4'd3, 13'h1040, 13'h1100, 13'h1FFE, 13'h103F}
  };

  logic [12:0] caseLocs [12];

  function automatic void chk(input bit ok, input string req, input string what,
                              input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endfunction

  task automatic runCase(input logic [2:0] sec, input logic [3:0] cnt,
                         input int doneDelay, input bit pokeBusy);
    int expKind [12];
    int expAddr [12];
    int expMask [12];
    int expN = 0;
    int seen = 0;
    bit bad = (cnt > 4'd12);
    bit gotResult = 0;
    if (!bad) begin
      for (int i = 0; i < int'(cnt); i++) begin
        int L = int'(caseLocs[i]);
        if (L < 4096) begin
          expKind[expN] = 1; expAddr[expN] = L >> 3; expMask[expN] = 1 << (L & 7); expN++;
        end else if (L < 4160) begin
          expKind[expN] = 2; expAddr[expN] = (L >> 3) - 512; expMask[expN] = 1 << (L & 7); expN++;
        end
      end
    end
    // junk in every other count field (R3); junk padding in words (R6)
    errCounts = 32'h9999_9999;
    errCounts[sec*4 +: 4] = cnt;
    for (int w = 0; w < 6; w++) begin
      locWords[w*32 +: 32] = {3'b0, caseLocs[2*w+1], 3'b0, caseLocs[2*w]};
    end
    doneFlags = ~(8'd1 << sec);
    @(negedge clk);
    sectorIdx = sec;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int cyc = 0; cyc < 40; cyc++) begin
      if (pokeBusy && cyc == 0) begin
        start = 1'b1;
        sectorIdx = sec + 3'd1;
      end else if (pokeBusy && cyc == 1) begin
        start = 1'b0;
      end
      if (cyc == doneDelay) doneFlags[sec] = 1'b1;
      if (cyc <= doneDelay) begin
        // R2: nothing may appear before the done flag is sampled
        if (dataFlip || metaFlip || resultValid)
          chk(1'b0, "R2", "activity before done", 1, 0);
      end
      if (dataFlip || metaFlip) begin
        int k = dataFlip ? 1 : 2;
        if (seen >= expN) begin
          chk(1'b0, "R9", "extra flip", seen + 1, expN);
        end else begin
          chk(k == expKind[seen], k == 1 ? "R7" : "R8", "flip target", k, expKind[seen]);
          chk(int'(flipByte) == expAddr[seen], k == 1 ? "R7" : "R8", "flip byte",
              int'(flipByte), expAddr[seen]);
          chk(int'(flipMask) == expMask[seen], "R10", "flip mask/order",
              int'(flipMask), expMask[seen]);
        end
        seen++;
      end
      if (resultValid) begin
        gotResult = 1;
        chk(uncorrectable == bad, bad ? "R5" : "R4", "uncorrectable flag",
            int'(uncorrectable), int'(bad));
        chk(int'(fixedCount) == expN, "R11", "fixed count", int'(fixedCount), expN);
        @(negedge clk);
        chk(!resultValid, "R11", "pulse length", int'(resultValid), 0);
        break;
      end
      @(negedge clk);
    end
    chk(gotResult, "R11", "result pulse seen", int'(gotResult), 1);
    chk(seen == expN, "R9", "flip total", seen, expN);
    // R12: a poked start must not launch a second run
    if (pokeBusy) begin
      int extra = 0;
      for (int c = 0; c < 10; c++) begin
        @(negedge clk);
        if (resultValid || dataFlip || metaFlip) extra++;
      end
      chk(extra == 0, "R12", "activity after busy start", extra, 0);
    end
    doneFlags = '0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: idle after reset, even with done flags and counts present
    doneFlags = '1;
    errCounts = 32'h2222_2222;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      chk(!(dataFlip || metaFlip || resultValid || uncorrectable), "R1", "idle outputs",
          int'({dataFlip, metaFlip, resultValid, uncorrectable}), 0);
    end
    doneFlags = '0;

    for (int v = 0; v < NV; v++) begin
      for (int i = 0; i < 12; i++) caseLocs[i] = 13'h0AAA;
      caseLocs[0] = VEC[v][51:39];
      caseLocs[1] = VEC[v][38:26];
      caseLocs[2] = VEC[v][25:13];
      caseLocs[3] = VEC[v][12:0];
      runCase(VEC[v][62:60], VEC[v][59:56], int'(VEC[v][55:52]), 1'b0);
    end

    // R4: count 4'hF with valid-looking locations
    for (int i = 0; i < 12; i++) caseLocs[i] = 13'(i * 8);
    runCase(3'd4, 4'hF, 1, 1'b0);
    // R5: count 13 exceeds the maximum
    runCase(3'd6, 4'd13, 0, 1'b0);
    // R6: twelve errors, reaching the odd half of the last word
    for (int i = 0; i < 12; i++) caseLocs[i] = 13'(i * 345 + 7);
    caseLocs[11] = 13'h1038;
    runCase(3'd7, 4'd12, 2, 1'b0);
    // R12: start while busy
    caseLocs[0] = 13'h0010; caseLocs[1] = 13'h1001;
    runCase(3'd0, 4'd2, 4, 1'b1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule